// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Squash Controller

This block is the hazard control for a five-stage in-order pipeline whose branch comparison and target adder sit in the decode stage. Every cycle it looks at the instruction in the execute-entry register and the one in the decode register. If a load in execute-entry writes a register that the decoding instruction reads, forwarding cannot supply the value in time. The block then freezes the program counter and the decode register for one cycle, and it forces the control bits entering execute to zero, so that a no-op bubble goes down the pipe.

Fetch assumes that branches are not taken. When decode reports a taken branch, the block clears the instruction just fetched. The decode register then captures a zeroed instruction field, a no-op, while the program counter loads the target. A taken branch therefore costs exactly one squashed instruction.

A small sequencer tracks the cycle that follows each action. It has three states:
- RUN: normal issue.
- HOLD: the cycle after a stall. The bubble is now in execute-entry, and the held instruction is decoded again.
- SQUASH: the cycle after a flush. The decode register holds the no-op.

It has five transitions:
- RUN→HOLD on a stall.
- RUN→SQUASH on a flush.
- HOLD→SQUASH on a branch taken while in HOLD.
- HOLD→RUN otherwise.
- SQUASH→RUN always.

If a stall and a taken branch coincide, the stall wins, and the branch is judged again in HOLD.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Out of reset the sequencer is in RUN. With no load and no taken branch, the outputs are pc_we=1, ifid_we=1, idex_ctrl_zero=0, ifid_flush=0.
- R2: In RUN, when ex_is_load=1, ex_dst_reg is nonzero and equal to dec_src_a or dec_src_b, the block stalls in that same cycle: pc_we=0, ifid_we=0, idex_ctrl_zero=1, ifid_flush=0.
- R3: A load whose destination is register 0 never causes a stall.
- R4: When ex_is_load=0, no stall occurs, whatever the register fields hold.
- R5: A stall lasts exactly one cycle. In the cycle after a stall (HOLD), a matching load is ignored and no stall is raised.
- R6: In RUN with no hazard, dec_branch_taken=1 gives ifid_flush=1, pc_we=1, ifid_we=1, idex_ctrl_zero=0.
- R7: When a hazard and a taken branch occur together, only the stall is issued. If dec_branch_taken is 1 in the following (HOLD) cycle, the flush is issued then.
- R8: In the cycle after a flush (SQUASH), dec_branch_taken and any hazard are ignored and the outputs are the pass-through values of R1.
- R9: idex_ctrl_zero and ifid_flush are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_is_load | input | 1 | Execute-entry instruction reads data memory |
| ex_dst_reg | input | REG_W | Destination register of the execute-entry instruction |
| dec_src_a | input | REG_W | First source register field in the decode register |
| dec_src_b | input | REG_W | Second source register field in the decode register |
| dec_branch_taken | input | 1 | Decode resolved a taken branch |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Decode register write enable |
| idex_ctrl_zero | output | 1 | Force execute-entry control bits to zero (bubble) |
| ifid_flush | output | 1 | Zero the instruction field captured by the decode register |

## Verification
The assertions check the following properties on every cycle:
- A stall holds both write enables low.
- A stall and a flush never coincide.
- Neither a stall nor a flush is followed directly by another stall.
- A zero destination or a non-load never stalls.
- A branch deferred by a stall is flushed one cycle later.

The exact hazard condition, across every pairing of destination and source fields, can only be shown by the bench's sweep. The same holds for the two-cycle sequences that show inputs being ignored in HOLD and SQUASH.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SQUASH = 2'd2
    } phc_state_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_zero;
        logic ifid_flush;
    } phc_ctl_t;

    localparam phc_ctl_t CTL_PASS  = '{pc_we: 1'b1, ifid_we: 1'b1, idex_zero: 1'b0, ifid_flush: 1'b0};
    localparam phc_ctl_t CTL_STALL = '{pc_we: 1'b0, ifid_we: 1'b0, idex_zero: 1'b1, ifid_flush: 1'b0};
    localparam phc_ctl_t CTL_FLUSH = '{pc_we: 1'b1, ifid_we: 1'b1, idex_zero: 1'b0, ifid_flush: 1'b1};

endpackage

// File: rtl/phc_src_match.sv
module phc_src_match #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            ld_valid,
    input  logic [REG_W-1:0]                dst,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   srcs,
    output logic                            hit
);
    logic [NUM_SRC-1:0] match;
    logic               dst_live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign match[g] = (srcs[g] == dst);
    end

    // register 0 is hardwired, so a load into it creates no dependence
    assign dst_live = ld_valid && (dst != '0);
    assign hit      = dst_live && (|match);
endmodule

// File: rtl/phc_ctrl_fsm.sv
module phc_ctrl_fsm
    import phc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hazard,
    input  logic     br_taken,
    output phc_ctl_t ctl
);
    phc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (hazard)        state_d = ST_HOLD;
                else if (br_taken) state_d = ST_SQUASH;
                else               state_d = ST_RUN;
            end
            ST_HOLD: begin
                if (br_taken) state_d = ST_SQUASH;
                else          state_d = ST_RUN;
            end
            ST_SQUASH: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        ctl = CTL_PASS;
        unique case (state_q)
            ST_RUN: begin
                if (hazard)        ctl = CTL_STALL;
                else if (br_taken) ctl = CTL_FLUSH;
                else               ctl = CTL_PASS;
            end
            ST_HOLD: begin
                // bubble already sits in execute-entry; only the branch is re-judged
                if (br_taken) ctl = CTL_FLUSH;
                else          ctl = CTL_PASS;
            end
            ST_SQUASH: ctl = CTL_PASS;
            default:   ctl = CTL_PASS;
        endcase
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import phc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_dst_reg,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_branch_taken,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_ctrl_zero,
    output logic             ifid_flush
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic                          hazard;
    phc_ctl_t                      ctl;

    assign srcs = {dec_src_b, dec_src_a};

    phc_src_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
        .ld_valid (ex_is_load),
        .dst      (ex_dst_reg),
        .srcs     (srcs),
        .hit      (hazard)
    );

    phc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard   (hazard),
        .br_taken (dec_branch_taken),
        .ctl      (ctl)
    );

    assign pc_we          = ctl.pc_we;
    assign ifid_we        = ctl.ifid_we;
    assign idex_ctrl_zero = ctl.idex_zero;
    assign ifid_flush     = ctl.ifid_flush;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_is_load,
    input logic [REG_W-1:0] ex_dst_reg,
    input logic             dec_branch_taken,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_ctrl_zero,
    input logic             ifid_flush
);
    assert_stall_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idex_ctrl_zero |-> (!pc_we && !ifid_we && ex_is_load));

    assert_zero_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst_reg == '0) |-> !idex_ctrl_zero);

    assert_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !idex_ctrl_zero);

    assert_one_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idex_ctrl_zero |=> !idex_ctrl_zero);

    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (dec_branch_taken && pc_we && ifid_we));

    assert_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_ctrl_zero && dec_branch_taken) ##1 dec_branch_taken |-> ifid_flush);

    assert_quiet_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> (!ifid_flush && !idex_ctrl_zero));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(idex_ctrl_zero && ifid_flush));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ex_is_load       (ex_is_load),
    .ex_dst_reg       (ex_dst_reg),
    .dec_branch_taken (dec_branch_taken),
    .pc_we            (pc_we),
    .ifid_we          (ifid_we),
    .idex_ctrl_zero   (idex_ctrl_zero),
    .ifid_flush       (ifid_flush)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
    localparam int RW   = 3;
    localparam int NREG = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_is_load = 1'b0;
    logic [RW-1:0] ex_dst_reg = '0;
    logic [RW-1:0] dec_src_a = '0;
    logic [RW-1:0] dec_src_b = '0;
    logic          dec_branch_taken = 1'b0;
    logic          pc_we, ifid_we, idex_ctrl_zero, ifid_flush;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // expected output words {pc_we, ifid_we, idex_ctrl_zero, ifid_flush}
    localparam logic [3:0] E_PASS  = 4'b1100;
    localparam logic [3:0] E_STALL = 4'b0010;
    localparam logic [3:0] E_FLUSH = 4'b1101;

    pipe_hazard_ctrl #(.REG_W(RW)) u_pipe_hazard_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .ex_is_load       (ex_is_load),
        .ex_dst_reg       (ex_dst_reg),
        .dec_src_a        (dec_src_a),
        .dec_src_b        (dec_src_b),
        .dec_branch_taken (dec_branch_taken),
        .pc_we            (pc_we),
        .ifid_we          (ifid_we),
        .idex_ctrl_zero   (idex_ctrl_zero),
        .ifid_flush       (ifid_flush)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 200000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_we, ifid_we, idex_ctrl_zero, ifid_flush};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b (load=%0b dst=%0d a=%0d b=%0d br=%0b)",
                     tag, act, exp, ex_is_load, ex_dst_reg, dec_src_a, dec_src_b, dec_branch_taken);
        end
    endtask

    task automatic drive(input logic ld, input int d, input int a, input int b, input logic br);
        @(negedge clk);
        ex_is_load       = ld;
        ex_dst_reg       = RW'(d);
        dec_src_a        = RW'(a);
        dec_src_b        = RW'(b);
        dec_branch_taken = br;
        #1;
    endtask

    initial begin
        // R1: outputs pass through while held in reset and just after it
        #1;
        check("R1 in reset", E_PASS);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 0, 0, 0, 1'b0);
        check("R1 after reset", E_PASS);

        for (int ld = 0; ld < 2; ld++) begin
            for (int d = 0; d < NREG; d++) begin
                for (int a = 0; a < NREG; a++) begin
                    for (int b = 0; b < NREG; b++) begin
                        for (int br = 0; br < 2; br++) begin
                            bit hz;
                            logic [3:0] e1, e2;
                            string t1, t2;
                            hz = (ld == 1) && (d != 0) && ((d == a) || (d == b));
                            // two idle cycles return the sequencer to RUN
                            drive(1'b0, 0, 0, 0, 1'b0);
                            drive(1'b0, 0, 0, 0, 1'b0);
                            check("R1 idle", E_PASS);
                            if (hz) begin
                                e1 = E_STALL;
                                t1 = (br == 1) ? "R7 stall wins, R9" : "R2 stall";
                                e2 = (br == 1) ? E_FLUSH : E_PASS;
                                t2 = (br == 1) ? "R7 retry flush" : "R5 single stall";
                            end else if (br == 1) begin
                                e1 = E_FLUSH;
                                t1 = (ld == 0) ? "R4 R6 flush" : ((d == 0) ? "R3 R6 flush" : "R6 flush");
                                e2 = E_PASS;
                                t2 = "R8 after flush";
                            end else begin
                                e1 = E_PASS;
                                t1 = (ld == 0) ? "R4 no stall" : ((d == 0) ? "R3 zero dst" : "R2 no match");
                                e2 = E_PASS;
                                t2 = "R1 steady";
                            end
                            drive(ld[0], d, a, b, br[0]);
                            check(t1, e1);
                            // same inputs again: HOLD or SQUASH must ignore them
                            drive(ld[0], d, a, b, br[0]);
                            check(t2, e2);
                        end
                    end
                end
            end
        end

        // R8: a hazard appearing right after a flush is ignored
        drive(1'b0, 0, 0, 0, 1'b0);
        drive(1'b0, 0, 0, 0, 1'b1);
        check("R6 flush", E_FLUSH);
        drive(1'b1, 3, 3, 0, 1'b1);
        check("R8 hazard ignored", E_PASS);
        drive(1'b1, 3, 3, 0, 1'b0);
        check("R2 stall after squash", E_STALL);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule